// File: doc/BRIEF.md
# Serial Clock Synthesizer Programmer

This block loads a frequency setting into an external clock synthesizer through two pins, a clock pin and a data pin. A single start strobe captures a register index and three divider fields (N, P and D). The block packs them into a 24-bit control word whose top three bits always select the synthesizer's second internal register. It then drives the pins through a fixed sequence: an unlock preamble, a start bit, the 24 data bits and a stop bit.

Each data bit is sent in a modified Manchester form. The complement of the bit is on the data pin at the clock pin's falling edge, and the true value is there at the following rising edge. Every pin state is held for a programmable number of system clock cycles. The whole transaction can be repeated back to back, so that the synthesizer reliably accepts it. Three repetitions is the usual setting.

While the transfer runs, a busy flag is high. When the last repetition ends, the block emits a one-cycle done pulse and the pins return to their idle level.

Top module: `synth_prog`

## Requirements
- R1: After reset, clk_pin = 1, data_pin = 1, busy = 0 and done = 0.
- R2: The control word has 24 bits. Bits 23:21 are 3'b010, bits 20:17 are sel_idx, bits 16:10 are n_div, bits 9:7 are p_div and bits 6:0 are d_div.
- R3: Each transaction opens with an unlock preamble of 14 pin states, written as (data,clk). The order is (0,0), (1,0), then five pairs of (1,1),(1,0), then (0,0), (0,1).
- R4: After the preamble comes a start bit of two pin states, (0,0) then (0,1).
- R5: The 24 word bits follow, least significant bit first, with four pin states each. A bit b is sent as (~b,1), (~b,0), (b,0), (b,1). Between consecutive states inside a transaction, at most one pin changes.
- R6: Each transaction closes with a stop bit of three pin states: (1,1), (1,0), (1,1).
- R7: Each pin state is held for half_div system clock cycles. A half_div of 0 behaves as 1.
- R8: The transaction (115 pin states) is sent reps times in a row without a gap. A reps value of 0 behaves as 1. busy is high for exactly reps × 115 × half_div cycles, with both clamps applied.
- R9: All field, divider and repeat inputs are captured when start is seen while the block is idle. A start strobe or a change of any input while busy has no effect on the pin sequence or its length.
- R10: When the last pin state of the last repetition ends, busy falls and done is high for exactly one cycle. In that cycle the pins are at idle (1,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; used only when idle |
| sel_idx | input | 4 | Register index field |
| n_div | input | 7 | N divider field |
| p_div | input | 3 | P divider field |
| d_div | input | 7 | D divider field |
| half_div | input | DIV_W | System cycles per pin state |
| reps | input | REP_W | Number of transactions |
| clk_pin | output | 1 | Clock pin to synthesizer |
| data_pin | output | 1 | Data pin to synthesizer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its defaults, DIV_W = 8 and REP_W = 2. With those widths, repeat counts up to three and small hold values are available. A hold of three cycles and three back-to-back transactions both appear in the table. All-zero inputs exercise the clamps on half_div and reps, while all-ones fields exercise the full field widths. A disturbed run shows that a second strobe and changing inputs during a transfer leave the pin trace untouched.

// File: rtl/synth_prog.sv
module synth_prog #(
  parameter int DIV_W = 8,
  parameter int REP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       sel_idx,
  input  logic [6:0]       n_div,
  input  logic [2:0]       p_div,
  input  logic [6:0]       d_div,
  input  logic [DIV_W-1:0] half_div,
  input  logic [REP_W-1:0] reps,
  output logic             clk_pin,
  output logic             data_pin,
  output logic             busy,
  output logic             done
);
  localparam int WORD_W   = 24;
  localparam int PRE_LEN  = 14;
  localparam int SB_LEN   = 2;
  localparam int DATA_LO  = PRE_LEN + SB_LEN;
  localparam int STOP_LO  = DATA_LO + 4 * WORD_W;
  localparam int TOTAL    = STOP_LO + 3;
  localparam int STEP_W   = $clog2(TOTAL);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(TOTAL - 1);

  logic [WORD_W-1:0] word;
  logic [DIV_W-1:0]  div_q, tick;
  logic [REP_W-1:0]  rep_tgt, rep_cnt;
  logic [STEP_W-1:0] step, rel;
  logic [1:0]        pins;
  logic              bitv;

  assign rel  = step - STEP_W'(DATA_LO);
  assign bitv = word[rel[STEP_W-1:2]];

  always_comb begin
    pins = 2'b11;
    if (busy) begin
      if (step < STEP_W'(PRE_LEN)) begin
        case (step)
          STEP_W'(0):  pins = 2'b00;
          STEP_W'(1):  pins = 2'b10;
          STEP_W'(12): pins = 2'b00;
          STEP_W'(13): pins = 2'b01;
          default:     pins = step[0] ? 2'b10 : 2'b11;
        endcase
      end else if (step < STEP_W'(DATA_LO)) begin
        pins = {1'b0, step[0]};
      end else if (step < STEP_W'(STOP_LO)) begin
        case (rel[1:0])
          2'd0:    pins = {~bitv, 1'b1};
          2'd1:    pins = {~bitv, 1'b0};
          2'd2:    pins = {bitv, 1'b0};
          default: pins = {bitv, 1'b1};
        endcase
      end else begin
        pins = (step == STEP_W'(STOP_LO + 1)) ? 2'b10 : 2'b11;
      end
    end
  end

  assign data_pin = pins[1];
  assign clk_pin  = pins[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      div_q   <= '0;
      tick    <= '0;
      rep_tgt <= '0;
      rep_cnt <= '0;
      step    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          word    <= {3'b010, sel_idx, n_div, p_div, d_div};
          div_q   <= (half_div == '0) ? DIV_W'(1) : half_div;
          rep_tgt <= (reps == '0) ? REP_W'(1) : reps;
          rep_cnt <= '0;
          tick    <= '0;
          step    <= '0;
          busy    <= 1'b1;
        end
      end else if (tick == div_q - 1'b1) begin
        tick <= '0;
        if (step == LAST) begin
          step <= '0;
          if (rep_cnt == rep_tgt - 1'b1) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            rep_cnt <= rep_cnt + 1'b1;
          end
        end else begin
          step <= step + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && clk_pin && data_pin));

  assert_busy_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_word_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (word == $past(word) && div_q == $past(div_q)));

  assert_tick_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick < div_q));

  assert_one_pin_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && step != '0 && pins != $past(pins))
      |-> ($countones(pins ^ $past(pins)) == 1));
endmodule

// File: tb/synth_prog_test.sv
module synth_prog_test;
  localparam int PERIOD = 10;
  localparam int MAXC   = 4096;

  localparam logic [30:0] VEC [0:3] = '{
    {4'h5, 7'h55, 3'd3, 7'h2A, 8'd1, 2'd3},
    {4'hF, 7'h7F, 3'd7, 7'h7F, 8'd2, 2'd1},
    {4'h0, 7'h00, 3'd0, 7'h00, 8'd0, 2'd0},
    {4'hA, 7'h13, 3'd5, 7'h61, 8'd3, 2'd2}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] sel_idx = 0;
  logic [6:0] n_div = 0, d_div = 0;
  logic [2:0] p_div = 0;
  logic [7:0] half_div = 0;
  logic [1:0] reps = 0;
  logic clk_pin, data_pin, busy, done;

  int tests = 0, fails = 0;
  logic [1:0] cap [MAXC];
  logic [1:0] expv [MAXC];
  int         regn [MAXC];
  int cap_len, exp_len;

  synth_prog uut (.clk(clk), .rst_n(rst_n), .start(start), .sel_idx(sel_idx),
    .n_div(n_div), .p_div(p_div), .d_div(d_div), .half_div(half_div),
    .reps(reps), .clk_pin(clk_pin), .data_pin(data_pin), .busy(busy), .done(done));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input int r, input int hold);
    for (int h = 0; h < hold; h++) begin
      expv[exp_len] = s;
      regn[exp_len] = r;
      exp_len++;
    end
  endtask

  task automatic build(input logic [23:0] w, input int hold, input int nrep);
    exp_len = 0;
    for (int r = 0; r < nrep; r++) begin
      put(2'b00, 0, hold); put(2'b10, 0, hold);
      for (int k = 0; k < 5; k++) begin put(2'b11, 0, hold); put(2'b10, 0, hold); end
      put(2'b00, 0, hold); put(2'b01, 0, hold);
      put(2'b00, 1, hold); put(2'b01, 1, hold);
      for (int b = 0; b < 24; b++) begin
        put({~w[b], 1'b1}, 2, hold); put({~w[b], 1'b0}, 2, hold);
        put({w[b], 1'b0}, 2, hold);  put({w[b], 1'b1}, 2, hold);
      end
      put(2'b11, 3, hold); put(2'b10, 3, hold); put(2'b11, 3, hold);
    end
  endtask

  task automatic run_vec(input logic [30:0] v, input bit disturb);
    int hold, nrep, bad [4], first [4];
    logic [23:0] w, got;
    hold = (v[9:2] == 0) ? 1 : int'(v[9:2]);
    nrep = (v[1:0] == 0) ? 1 : int'(v[1:0]);
    w = {3'b010, v[30:27], v[26:20], v[19:17], v[16:10]};
    build(w, hold, nrep);
    @(negedge clk);
    {sel_idx, n_div, p_div, d_div, half_div, reps} = v;
    start = 1;
    @(negedge clk);
    start = 0;
    {sel_idx, n_div, p_div, d_div, half_div, reps} = ~v;
    cap_len = 0;
    while (busy && cap_len < MAXC) begin
      cap[cap_len] = {data_pin, clk_pin};
      cap_len++;
      start = (disturb && cap_len == 20);
      @(negedge clk);
    end
    start = 0;
    chk(done === 1'b1 && {data_pin, clk_pin} === 2'b11, "R10", "done/idle at busy fall",
        {done, data_pin, clk_pin}, 3'b111);
    for (int k = 0; k < 4; k++) begin bad[k] = 0; first[k] = -1; end
    for (int i = 0; i < exp_len && i < cap_len; i++)
      if (cap[i] !== expv[i]) begin
        bad[regn[i]]++;
        if (first[regn[i]] < 0) first[regn[i]] = i;
      end
    chk(bad[0] == 0, "R3", "preamble states", first[0] < 0 ? 0 : cap[first[0]],
        first[0] < 0 ? 0 : expv[first[0]]);
    chk(bad[1] == 0, "R4", "start bit states", first[1] < 0 ? 0 : cap[first[1]],
        first[1] < 0 ? 0 : expv[first[1]]);
    chk(bad[2] == 0, "R5", "data bit states", first[2] < 0 ? 0 : cap[first[2]],
        first[2] < 0 ? 0 : expv[first[2]]);
    chk(bad[3] == 0, "R6", "stop bit states", first[3] < 0 ? 0 : cap[first[3]],
        first[3] < 0 ? 0 : expv[first[3]]);
    chk(cap_len == hold * 115 * nrep, "R7 R8", "busy length", cap_len, hold * 115 * nrep);
    got = '0;
    for (int b = 0; b < 24; b++)
      if ((16 + 4 * b + 3) * hold < cap_len) got[b] = cap[(16 + 4 * b + 3) * hold][1];
    chk(got === w, "R2", "word at rising edges", got, w);
    if (disturb)
      chk(bad[0] + bad[1] + bad[2] + bad[3] == 0 && cap_len == exp_len, "R9",
          "start/inputs while busy", cap_len, exp_len);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", "done single cycle", {done, busy}, 2'b00);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    @(negedge clk);
    chk({clk_pin, data_pin, busy, done} === 4'b1100, "R1", "reset state",
        {clk_pin, data_pin, busy, done}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    chk({clk_pin, data_pin, busy, done} === 4'b1100, "R1", "idle after reset",
        {clk_pin, data_pin, busy, done}, 4'b1100);
    for (int i = 0; i < 4; i++) run_vec(VEC[i], 1'b0);
    run_vec(VEC[3], 1'b1);
    run_vec({4'h9, 7'h01, 3'd4, 7'h40, 8'd0, 2'd3}, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule